// File: doc/BRIEF.md
# Double-Buffered PWM Compare Pair

This block turns two compare channels, an even one and an odd one, into one PWM output whose duty cycle can be changed at any time without a glitch. Software loads the first pulse width into the even channel's compare register. Each later width goes into whichever register is not driving the pin at that moment, and a write there arms it. At the next counter overflow the armed register takes over the pin. A jump from a width near the full period to a width near zero therefore never shortens or merges a period.

The timer base sits outside this block. It supplies the shared counter value, a strobe for each count, and an overflow strobe that is high in the cycle the counter shows zero after a wrap. The compare registers are loaded byte by byte. A status output tells software which register is active, so it knows which one to write next. While the pair is linked, the odd channel's pin is handed back to general-purpose port logic.

Top module: `pwm_pair_buf`

## Requirements
- R1: After reset `pwm_out` is 0, `active_ch` is 0 (even register active), no register is armed and both compare registers hold 0.
- R2: `odd_pin_release` equals `pair_link`. When it is 1 the odd channel's pin belongs to port logic, whatever the odd channel's own settings are.
- R3: Writes are bytewise. A write with `wr_byte` = 1 only stages the high byte. A write with `wr_byte` = 0 completes the 16-bit value {staged high byte, `wr_data`} of the channel picked by `wr_ch` (0 even, 1 odd). A staged high byte with no low-byte write arms nothing.
- R4: While linked, completing a write to the inactive register arms it. At the next `cnt_ovf` the armed register becomes active: `active_ch` flips (0 even, 1 odd) and is visible after the overflow cycle's clock edge.
- R5: While linked, if nothing is armed, `active_ch` and the active register stay the same across any number of overflows.
- R6: If the inactive register is completed more than once before an overflow, the last completed value is the one used after the switch.
- R7: The output is registered. When `cnt_step` is 1 and `cnt_val` equals the active register, `lvl_sel` applies: 01 toggle, 10 drive 0, 11 drive 1. With `lvl_sel` = 00, or when neither `pair_link` nor `even_mode_lo` is set, the output holds and overflow toggling is off as well.
- R8: When `ovf_toggle` is 1, `cnt_ovf` toggles the output, and this wins over a compare match in the same cycle.
- R9: With `lvl_sel` = 10 and `ovf_toggle` = 1 and a modulo period of M+1 counts, a compare value C in 1..M gives an output that is high for exactly C counts per period, from the overflow to the match. Modulo 0xFF with C = 0xC0 gives 75 %.
- R10: When unlinked with `even_mode_lo` = 1, only the even register drives the output and `active_ch` stays 0. Writes to the odd register do not change the output.
- R11: A width change written during a period leaves that period's width untouched and takes full effect in the next period. This includes jumps from M to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cnt_val | input | CNT_W | Shared counter value |
| cnt_step | input | 1 | Counter took a new value this cycle |
| cnt_ovf | input | 1 | Counter wrapped to zero this cycle |
| pair_link | input | 1 | Links the two channels as a buffered pair (even channel's high mode bit) |
| even_mode_lo | input | 1 | Even channel's low mode bit (compare mode when unlinked) |
| lvl_sel | input | 2 | Match action: 00 none, 01 toggle, 10 low, 11 high |
| ovf_toggle | input | 1 | Toggle the output on overflow |
| wr_en | input | 1 | Register byte write strobe |
| wr_ch | input | 1 | Target register: 0 even, 1 odd |
| wr_byte | input | BI_W | Byte index: 0 low byte (completes the write), higher bytes are staged |
| wr_data | input | 8 | Write data byte |
| pwm_out | output | 1 | PWM pin |
| odd_pin_release | output | 1 | Odd channel pin handed to port control |
| active_ch | output | 1 | Active register: 0 even, 1 odd |

## Verification
The bench sweeps every compare value of a 16-count period. It orders the values so that the full width and the minimum width alternate. In each period it measures the high time and checks that the width written during the period appears only one period later. A design that switched on the write instead of on the overflow would show a cut-short or double pulse at the change. The bench also covers a high-byte-only write, which must arm nothing, and two completed writes in one period, where the later value must win. It checks a compare of zero that meets the overflow: a design that let the match win there would hold the pin low for a whole period. The level codes and the unlinked mode are checked as well. A wrong decode would show up as high times that are inverted or frozen, or as a status bit that leaves the even register.

// File: rtl/pwm_pair_pkg.sv
package pwm_pair_pkg;

    typedef enum logic [1:0] {
        LVL_HOLD   = 2'b00,
        LVL_TOGGLE = 2'b01,
        LVL_LOW    = 2'b10,
        LVL_HIGH   = 2'b11
    } lvl_act_e;

    typedef struct packed {
        logic active;
        logic pending;
    } sel_state_t;

    typedef struct packed {
        logic pwm;
    } out_state_t;

endpackage

// File: rtl/pwm_pair_regs.sv
module pwm_pair_regs #(
    parameter int CNT_W = 16,
    parameter int NB    = CNT_W / 8,
    parameter int BI_W  = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  wr_ch,
    input  logic [BI_W-1:0]       wr_byte,
    input  logic [7:0]            wr_data,
    output logic [1:0][CNT_W-1:0] cmp_val,
    output logic [1:0]            commit
);

    for (genvar ch = 0; ch < 2; ch++) begin : g_ch
        typedef struct packed {
            logic [CNT_W-1:0] stage;
            logic [CNT_W-1:0] value;
        } reg_state_t;

        reg_state_t ch_d, ch_q;
        logic       sel;
        logic       done;

        assign sel = wr_en && (wr_ch == (ch != 0));

        always_comb begin
            ch_d = ch_q;
            done = 1'b0;
            if (sel) begin
                if (wr_byte == '0) begin
                    ch_d.value      = ch_q.stage;
                    ch_d.value[7:0] = wr_data;
                    done            = 1'b1;
                end else begin
                    for (int b = 1; b < NB; b++) begin
                        if (wr_byte == BI_W'(b)) begin
                            ch_d.stage[b*8 +: 8] = wr_data;
                        end
                    end
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ch_q <= '0;
            end else begin
                ch_q <= ch_d;
            end
        end

        assign cmp_val[ch] = ch_q.value;
        assign commit[ch]  = done;
    end

endmodule

// File: rtl/pwm_pair_select.sv
module pwm_pair_select
    import pwm_pair_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pair_link,
    input  logic       cnt_ovf,
    input  logic [1:0] commit,
    output logic       active,
    output logic       pending
);

    sel_state_t sel_d, sel_q;

    always_comb begin
        sel_d = sel_q;
        if (!pair_link) begin
            sel_d.active  = 1'b0;
            sel_d.pending = 1'b0;
        end else begin
            if (cnt_ovf && sel_q.pending) begin
                sel_d.active  = ~sel_q.active;
                sel_d.pending = 1'b0;
            end
            if (commit[~sel_d.active]) begin
                sel_d.pending = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= '0;
        end else begin
            sel_q <= sel_d;
        end
    end

    assign active  = sel_q.active;
    assign pending = sel_q.pending;

endmodule

// File: rtl/pwm_pair_outgen.sv
module pwm_pair_outgen
    import pwm_pair_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_step,
    input  logic             cnt_ovf,
    input  logic             run,
    input  logic             ovf_toggle,
    input  logic [1:0]       lvl_sel,
    input  logic [CNT_W-1:0] cmp_act,
    output logic             pwm_out
);

    out_state_t out_d, out_q;
    logic       hit;
    lvl_act_e   act;

    assign act = lvl_act_e'(lvl_sel);

    always_comb begin
        out_d = out_q;
        hit   = cnt_step && (cnt_val == cmp_act);
        if (run) begin
            if (cnt_ovf && ovf_toggle) begin
                out_d.pwm = ~out_q.pwm;
            end else if (hit) begin
                case (act)
                    LVL_TOGGLE: out_d.pwm = ~out_q.pwm;
                    LVL_LOW:    out_d.pwm = 1'b0;
                    LVL_HIGH:   out_d.pwm = 1'b1;
                    default:    out_d.pwm = out_q.pwm;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign pwm_out = out_q.pwm;

endmodule

// File: rtl/pwm_pair_buf.sv
module pwm_pair_buf #(
    parameter int CNT_W = 16,
    localparam int NB   = CNT_W / 8,
    localparam int BI_W = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt_val,
    input  logic             cnt_step,
    input  logic             cnt_ovf,
    input  logic             pair_link,
    input  logic             even_mode_lo,
    input  logic [1:0]       lvl_sel,
    input  logic             ovf_toggle,
    input  logic             wr_en,
    input  logic             wr_ch,
    input  logic [BI_W-1:0]  wr_byte,
    input  logic [7:0]       wr_data,
    output logic             pwm_out,
    output logic             odd_pin_release,
    output logic             active_ch
);

    logic [1:0][CNT_W-1:0] cmp_val;
    logic [1:0]            commit;
    logic                  pending;
    logic [CNT_W-1:0]      cmp_act;
    logic                  run;

    pwm_pair_regs #(.CNT_W(CNT_W), .NB(NB), .BI_W(BI_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_ch   (wr_ch),
        .wr_byte (wr_byte),
        .wr_data (wr_data),
        .cmp_val (cmp_val),
        .commit  (commit)
    );

    pwm_pair_select u_sel (
        .clk       (clk),
        .rst_n     (rst_n),
        .pair_link (pair_link),
        .cnt_ovf   (cnt_ovf),
        .commit    (commit),
        .active    (active_ch),
        .pending   (pending)
    );

    assign cmp_act = cmp_val[active_ch];
    assign run     = (pair_link || even_mode_lo) && (lvl_sel != 2'b00);

    pwm_pair_outgen #(.CNT_W(CNT_W)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnt_val    (cnt_val),
        .cnt_step   (cnt_step),
        .cnt_ovf    (cnt_ovf),
        .run        (run),
        .ovf_toggle (ovf_toggle),
        .lvl_sel    (lvl_sel),
        .cmp_act    (cmp_act),
        .pwm_out    (pwm_out)
    );

    assign odd_pin_release = pair_link;

endmodule

// File: rtl/pwm_pair_buf_chk.sv
module pwm_pair_buf_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [CNT_W-1:0] cnt_val,
    input logic             cnt_step,
    input logic             cnt_ovf,
    input logic             pair_link,
    input logic             even_mode_lo,
    input logic [1:0]       lvl_sel,
    input logic             ovf_toggle,
    input logic             pwm_out,
    input logic             active_ch,
    input logic [CNT_W-1:0] cmp_act
);

    logic chk_run;
    assign chk_run = (pair_link || even_mode_lo) && (lvl_sel != 2'b00);

    // R5: without an overflow the active register cannot change
    p_hold_active_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_link && !cnt_ovf) |=> $stable(active_ch));

    // R10: unlinked pair always uses the even register
    p_even_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !pair_link |=> !active_ch);

    // R8: overflow toggle wins
    p_ovf_toggles_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_ovf && ovf_toggle && chk_run) |=> (pwm_out != $past(pwm_out)));

    // R7: no count and no overflow leaves the pin alone
    p_quiet_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_ovf && !cnt_step) |=> $stable(pwm_out));

    // R9: a match in clear mode drives the pin low
    p_match_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_step && !cnt_ovf && chk_run && lvl_sel == 2'b10 && cnt_val == cmp_act)
        |=> !pwm_out);

endmodule

bind pwm_pair_buf pwm_pair_buf_chk #(.CNT_W(CNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cnt_val      (cnt_val),
    .cnt_step     (cnt_step),
    .cnt_ovf      (cnt_ovf),
    .pair_link    (pair_link),
    .even_mode_lo (even_mode_lo),
    .lvl_sel      (lvl_sel),
    .ovf_toggle   (ovf_toggle),
    .pwm_out      (pwm_out),
    .active_ch    (active_ch),
    .cmp_act      (cmp_act)
);

// File: tb/sim_pwm_pair_buf.sv
module sim_pwm_pair_buf;

    localparam int MOD = 15;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cnt_val = 16'h8000;
    logic        cnt_step = 1'b0;
    logic        cnt_ovf = 1'b0;
    logic        pair_link = 1'b0;
    logic        even_mode_lo = 1'b0;
    logic [1:0]  lvl_sel = 2'b10;
    logic        ovf_toggle = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_ch = 1'b0;
    logic [0:0]  wr_byte = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        pwm_out;
    logic        odd_pin_release;
    logic        active_ch;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    int          plan_n = 0;
    bit          plan_hionly = 1'b0;
    logic        plan_sel = 1'b0;
    logic [15:0] plan_v0 = '0;
    logic [15:0] plan_v1 = '0;
    logic        act_start;

    always #10 clk = ~clk;

    pwm_pair_buf u0 (
        .clk(clk), .rst_n(rst_n), .cnt_val(cnt_val), .cnt_step(cnt_step),
        .cnt_ovf(cnt_ovf), .pair_link(pair_link), .even_mode_lo(even_mode_lo),
        .lvl_sel(lvl_sel), .ovf_toggle(ovf_toggle), .wr_en(wr_en), .wr_ch(wr_ch),
        .wr_byte(wr_byte), .wr_data(wr_data), .pwm_out(pwm_out),
        .odd_pin_release(odd_pin_release), .active_ch(active_ch)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic ch, input logic [15:0] v, input bit hi_only);
        @(negedge clk);
        cnt_step = 1'b0; cnt_ovf = 1'b0; cnt_val = 16'h8000;
        wr_en = 1'b1; wr_ch = ch; wr_byte = 1'b1; wr_data = v[15:8];
        if (!hi_only) begin
            @(negedge clk);
            wr_byte = 1'b0; wr_data = v[7:0];
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_period(output int hi);
        hi = 0;
        for (int i = 0; i <= MOD; i++) begin
            @(negedge clk);
            cnt_val = 16'(i); cnt_step = 1'b1; cnt_ovf = (i == 0); wr_en = 1'b0;
            if (plan_n > 0 && (i == 2 || (i == 3 && !plan_hionly))) begin
                wr_en = 1'b1; wr_ch = plan_sel; wr_byte = 1'(i == 2);
                wr_data = (i == 2) ? plan_v0[15:8] : plan_v0[7:0];
            end
            if (plan_n > 1 && (i == 4 || i == 5)) begin
                wr_en = 1'b1; wr_ch = plan_sel; wr_byte = 1'(i == 4);
                wr_data = (i == 4) ? plan_v1[15:8] : plan_v1[7:0];
            end
            @(posedge clk);
            #5;
            if (i == 0) act_start = active_ch;
            if (pwm_out) hi++;
        end
        @(negedge clk);
        cnt_step = 1'b0; cnt_ovf = 1'b0; wr_en = 1'b0; cnt_val = 16'h8000;
        plan_n = 0; plan_hionly = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int hi;
        int prev;
        logic act;
        int v;

        repeat (3) @(posedge clk);
        #5;
        chk("R1 pwm_out after reset", int'(pwm_out), 0);
        chk("R1 active_ch after reset", int'(active_ch), 0);
        chk("R2 release while unlinked", int'(odd_pin_release), 0);
        @(negedge clk);
        rst_n = 1'b1;

        // linked pair, clear on match, toggle on overflow
        pair_link = 1'b1;
        #1;
        chk("R2 release while linked", int'(odd_pin_release), 1);
        bus_write(1'b0, 16'd12, 1'b0);

        // R3: high byte only to odd register arms nothing
        plan_n = 1; plan_hionly = 1'b1; plan_sel = 1'b1; plan_v0 = 16'h0300;
        run_period(hi);
        chk("R9 initial width from even register", hi, 12);
        chk("R1 even register active first", int'(act_start), 0);
        run_period(hi);
        chk("R3 staged high byte arms nothing (width)", hi, 12);
        chk("R3 staged high byte arms nothing (active)", int'(act_start), 0);
        run_period(hi);
        chk("R5 active kept without write", int'(act_start), 0);

        // R4 / R9 / R11 sweep, alternating extremes
        prev = 12; act = 1'b0;
        for (int k = 0; k < MOD; k++) begin
            v = (k % 2 == 0) ? (MOD - k / 2) : (1 + k / 2);
            plan_n = 1; plan_sel = ~act; plan_v0 = 16'(v);
            run_period(hi);
            chk("R11 write keeps current period width", hi, prev);
            chk("R4 active at period start", int'(act_start), int'(act));
            act = ~act;
            prev = v;
        end
        run_period(hi);
        chk("R9 last swept width", hi, prev);
        chk("R4 final switch", int'(act_start), int'(act));

        // R6: two completed writes, last wins
        plan_n = 2; plan_sel = ~act; plan_v0 = 16'd3; plan_v1 = 16'd7;
        run_period(hi);
        chk("R6 current period unchanged", hi, prev);
        act = ~act;
        run_period(hi);
        chk("R6 last completed value used", hi, 7);

        // R8: compare zero collides with overflow
        plan_n = 1; plan_sel = ~act; plan_v0 = 16'd0;
        run_period(hi);
        chk("R8 period before collision", hi, 7);
        act = ~act;
        run_period(hi);
        chk("R8 no match after toggle-high", hi, MOD + 1);
        run_period(hi);
        chk("R8 collision from high", hi, 0);
        plan_n = 1; plan_sel = ~act; plan_v0 = 16'd5;
        run_period(hi);
        chk("R8 overflow wins over match from low", hi, MOD + 1);
        act = ~act;
        run_period(hi);
        chk("R8 first period after width 5", hi, 0);
        run_period(hi);
        chk("R9 width 5", hi, 5);

        // R7 level codes
        lvl_sel = 2'b11;
        run_period(hi);
        chk("R7 set code from low", hi, MOD + 1);
        run_period(hi);
        chk("R7 set code from high", hi, MOD - 4);
        lvl_sel = 2'b01;
        run_period(hi);
        chk("R7 toggle code", hi, MOD - 4);
        lvl_sel = 2'b00;
        run_period(hi);
        chk("R7 code 00 holds", hi, MOD + 1);
        lvl_sel = 2'b10; ovf_toggle = 1'b0;
        run_period(hi);
        chk("R7 clear without overflow toggle", hi, 5);
        run_period(hi);
        chk("R7 stays low without overflow toggle", hi, 0);
        ovf_toggle = 1'b1;
        run_period(hi);
        chk("R9 width 5 restored", hi, 5);

        // R10 unlinked mode
        @(negedge clk);
        pair_link = 1'b0; even_mode_lo = 1'b1;
        #1;
        chk("R2 release cleared", int'(odd_pin_release), 0);
        bus_write(1'b0, 16'd4, 1'b0);
        plan_n = 1; plan_sel = 1'b1; plan_v0 = 16'd9;
        run_period(hi);
        chk("R10 even register drives", hi, 4);
        chk("R10 active forced even", int'(act_start), 0);
        run_period(hi);
        chk("R10 odd write ignored", hi, 4);
        chk("R10 active still even", int'(act_start), 0);
        lvl_sel = 2'b11;
        run_period(hi);
        chk("R7 set code unlinked", hi, MOD + 1);
        even_mode_lo = 1'b0;
        run_period(hi);
        chk("R10 no mode holds output", hi, MOD + 1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule